// File: doc/BRIEF.md
# Dual-Port Burst-of-Two Memory with Same-Cycle Write Forwarding

This block models a small synchronous memory. It has one read port and one write port. A read command and a write command, each with its own address, can be presented in the same clock cycle. Each command moves a burst of two data beats. The beats travel on consecutive clock edges. Write beat 0 is supplied with the command and write beat 1 in the cycle after it. Read beat 0 appears two cycles after the read command and read beat 1 one cycle later. `rd_valid` is high during both read beats.

Reads see writes that were issued in earlier cycles. One case needs forwarding: a read and a write with equal addresses in the same cycle. In that case the read returns the incoming write burst, merged byte by byte with the stored bytes that the write leaves untouched. It does not return the older stored contents. Every beat carries a byte enable for each byte lane.

Each port accepts a burst at most every other cycle. A request that arrives while the port is still busy with the second beat of the previous burst is dropped. When requests are held high, bursts run back to back with no gap.

Top module: `burst2_sram`

## Requirements
- R1: After synchronous reset, `rd_valid` is low, `rd_data` is zero and every location reads as zero on both beats.
- R2: A read request accepted in cycle C drives `rd_valid` high in cycles C+2 and C+3. `rd_data` carries beat 0 of the addressed burst in C+2 and beat 1 in C+3.
- R3: While `rd_valid` is low, `rd_data` is all zeros.
- R4: A write accepted in cycle C takes beat 0 from `wr_data`/`wr_be` in cycle C and beat 1 from `wr_data`/`wr_be` in cycle C+1. Byte lane j is bits [8j+7:8j] of a beat. Lane j is stored only when `wr_be[j]` is 1; every other lane keeps its value.
- R5: A read accepted in any cycle after the cycle of an accepted write returns that write's data, including a read in the very next cycle.
- R6: When a read and a write are accepted in the same cycle at the same address, each read beat equals the corresponding write beat in its enabled lanes and the previously stored bytes in the other lanes. For beat 1 this is the beat supplied in the following cycle.
- R7: A read accepted in a cycle before a write to the same address is accepted returns the contents from before that write.
- R8: A request on either port in the cycle right after that port accepted a request is ignored, and the ignored request does not change storage or read output. Requests held high are accepted every other cycle, and the `rd_valid` stream then has no gaps.
- R9: A read and a write accepted in the same cycle at different addresses do not interact: the read returns its own stored data and the write is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request strobe |
| rd_addr | input | AW (4) | Read burst address |
| wr_req | input | 1 | Write request strobe |
| wr_addr | input | AW (4) | Write burst address |
| wr_data | input | BEAT_W (16) | Write beat: beat 0 with the command, beat 1 in the next cycle |
| wr_be | input | BEAT_W/8 (2) | Byte enables for the current write beat |
| rd_data | output | BEAT_W (16) | Read beat data, zero when idle |
| rd_valid | output | 1 | High during the two beats of each read burst |

## Verification
The assertions run on every cycle. They check the read timing against the port-level acceptance rule: both beats must appear two and three cycles after an accepted read, no beat may appear at any other time, data must be zero while idle, and the output must be quiet after reset. They do not check the data values. Only the bench's scenarios can show which data a beat should carry. These scenarios cover byte-masked storage, reads that follow a write by one cycle or more, reads that precede a write, same-cycle forwarding with partial byte enables, same-cycle traffic to different addresses, and the dropped requests that must leave storage untouched.

// File: rtl/burst2_pkg.sv
package burst2_pkg;

    localparam int unsigned DEF_DEPTH  = 16;
    localparam int unsigned DEF_BEAT_W = 16;
    localparam int unsigned DEF_BYTE_W = 8;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_TAIL = 1'b1
    } rd_phase_e;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/burst2_merge.sv
module burst2_merge #(
    parameter int unsigned BEAT_W = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned NB = BEAT_W / BYTE_W
) (
    input  logic [BEAT_W-1:0] old_w,
    input  logic [BEAT_W-1:0] new_w,
    input  logic [NB-1:0]     be,
    output logic [BEAT_W-1:0] merged
);

    for (genvar j = 0; j < NB; j++) begin : g_lane
        assign merged[j*BYTE_W +: BYTE_W] = be[j] ? new_w[j*BYTE_W +: BYTE_W]
                                                  : old_w[j*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/burst2_array.sv
module burst2_array #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned BEAT_W = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned AW = burst2_pkg::addr_bits(DEPTH),
    localparam int unsigned NB = BEAT_W / BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [1:0][BEAT_W-1:0] wdata,
    input  logic [1:0][NB-1:0]     wbe,
    input  logic [AW-1:0]          raddr,
    output logic [1:0][BEAT_W-1:0] rdata,
    output logic [1:0][BEAT_W-1:0] wnext
);

    logic [1:0][BEAT_W-1:0] mem [DEPTH];

    // next contents of the write location, lane by lane
    for (genvar b = 0; b < 2; b++) begin : g_beat
        burst2_merge #(
            .BEAT_W (BEAT_W),
            .BYTE_W (BYTE_W)
        ) u_merge (
            .old_w  (mem[waddr][b]),
            .new_w  (wdata[b]),
            .be     (wbe[b]),
            .merged (wnext[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wnext;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/burst2_wr_slot.sv
module burst2_wr_slot #(
    parameter int unsigned AW     = 4,
    parameter int unsigned BEAT_W = 16,
    parameter int unsigned NB     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [AW-1:0]     addr,
    input  logic [BEAT_W-1:0] data,
    input  logic [NB-1:0]     be,
    output logic              s_vld,
    output logic [AW-1:0]     s_addr,
    output logic [BEAT_W-1:0] s_data,
    output logic [NB-1:0]     s_be
);

    logic accept;

    // the cycle after an accepted write belongs to its second beat
    assign accept = req && !s_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_vld  <= 1'b0;
            s_addr <= '0;
            s_data <= '0;
            s_be   <= '0;
        end else begin
            s_vld <= accept;
            if (accept) begin
                s_addr <= addr;
                s_data <= data;
                s_be   <= be;
            end
        end
    end

endmodule

// File: rtl/burst2_rd_pipe.sv
module burst2_rd_pipe
    import burst2_pkg::*;
#(
    parameter int unsigned AW     = 4,
    parameter int unsigned BEAT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [AW-1:0]          addr,
    output logic                   s_vld,
    output logic [AW-1:0]          s_addr,
    input  logic [1:0][BEAT_W-1:0] fetch,
    output logic [BEAT_W-1:0]      rd_data,
    output logic                   rd_valid
);

    rd_phase_e         phase;
    logic [BEAT_W-1:0] tail;
    logic              accept;

    assign accept = req && !s_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_vld    <= 1'b0;
            s_addr   <= '0;
            phase    <= PH_IDLE;
            tail     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            s_vld <= accept;
            if (accept) begin
                s_addr <= addr;
            end
            if (s_vld) begin
                // both beats fetched together; beat 1 waits one cycle
                rd_data  <= fetch[0];
                tail     <= fetch[1];
                rd_valid <= 1'b1;
                phase    <= PH_TAIL;
            end else if (phase == PH_TAIL) begin
                rd_data  <= tail;
                rd_valid <= 1'b1;
                phase    <= PH_IDLE;
            end else begin
                rd_data  <= '0;
                rd_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
    import burst2_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned BEAT_W = DEF_BEAT_W,
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    localparam int unsigned AW = addr_bits(DEPTH),
    localparam int unsigned NB = BEAT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    input  logic              wr_req,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BEAT_W-1:0] wr_data,
    input  logic [NB-1:0]     wr_be,
    output logic [BEAT_W-1:0] rd_data,
    output logic              rd_valid
);

    logic                   rs_vld;
    logic [AW-1:0]          rs_addr;
    logic                   ws_vld;
    logic [AW-1:0]          ws_addr;
    logic [BEAT_W-1:0]      ws_data;
    logic [NB-1:0]          ws_be;
    logic [1:0][BEAT_W-1:0] arr_wdata;
    logic [1:0][NB-1:0]     arr_wbe;
    logic [1:0][BEAT_W-1:0] arr_rdata;
    logic [1:0][BEAT_W-1:0] arr_wnext;
    logic [1:0][BEAT_W-1:0] fetch;
    logic                   fwd;

    burst2_wr_slot #(
        .AW     (AW),
        .BEAT_W (BEAT_W),
        .NB     (NB)
    ) u_wslot (
        .clk    (clk),
        .rst    (rst),
        .req    (wr_req),
        .addr   (wr_addr),
        .data   (wr_data),
        .be     (wr_be),
        .s_vld  (ws_vld),
        .s_addr (ws_addr),
        .s_data (ws_data),
        .s_be   (ws_be)
    );

    // beat 0 was captured with the command; beat 1 is on the pins now
    always_comb begin
        arr_wdata[0] = ws_data;
        arr_wdata[1] = wr_data;
        arr_wbe[0]   = ws_be;
        arr_wbe[1]   = wr_be;
    end

    burst2_array #(
        .DEPTH  (DEPTH),
        .BEAT_W (BEAT_W),
        .BYTE_W (BYTE_W)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (ws_vld),
        .waddr (ws_addr),
        .wdata (arr_wdata),
        .wbe   (arr_wbe),
        .raddr (rs_addr),
        .rdata (arr_rdata),
        .wnext (arr_wnext)
    );

    // a read and write captured together at one address: take the merged
    // write burst that the array is committing on this same edge
    assign fwd   = rs_vld && ws_vld && (rs_addr == ws_addr);
    assign fetch = fwd ? arr_wnext : arr_rdata;

    burst2_rd_pipe #(
        .AW     (AW),
        .BEAT_W (BEAT_W)
    ) u_rpipe (
        .clk      (clk),
        .rst      (rst),
        .req      (rd_req),
        .addr     (rd_addr),
        .s_vld    (rs_vld),
        .s_addr   (rs_addr),
        .fetch    (fetch),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk #(
    parameter int unsigned BEAT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic [BEAT_W-1:0] rd_data,
    input logic              rd_valid
);

    logic acc, a1, a2, a3;

    // port-level acceptance: a read is taken unless one was taken last cycle
    assign acc = rd_req && !a1;

    always_ff @(posedge clk) begin
        if (rst) begin
            a1 <= 1'b0;
            a2 <= 1'b0;
            a3 <= 1'b0;
        end else begin
            a1 <= acc;
            a2 <= a1;
            a3 <= a2;
        end
    end

    // R2
    rd_first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        a2 |-> rd_valid);

    // R2
    rd_second_beat_chk: assert property (@(posedge clk) disable iff (rst)
        a3 |-> rd_valid);

    // R8
    rd_no_stray_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (!a2 && !a3) |-> !rd_valid);

    // R3
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!rd_valid && rd_data == '0));

endmodule

bind burst2_sram burst2_sram_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/sim_burst2_sram.sv
module sim_burst2_sram;

    localparam int unsigned DEPTH  = 16;
    localparam int unsigned BEAT_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NB     = BEAT_W / BYTE_W;
    localparam int unsigned AW     = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_req = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic              wr_req = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [BEAT_W-1:0] wr_data = '0;
    logic [NB-1:0]     wr_be = '0;
    logic [BEAT_W-1:0] rd_data;
    logic              rd_valid;

    always #4 clk = ~clk;

    burst2_sram #(
        .DEPTH  (DEPTH),
        .BEAT_W (BEAT_W),
        .BYTE_W (BYTE_W)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int unsigned cyc_cnt = 0;
    bit          running = 1'b0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // reference storage and scoreboard
    logic [BEAT_W-1:0] model [DEPTH][2];
    logic [BEAT_W-1:0] q_data [$];
    int unsigned       q_cyc  [$];
    string             q_tag  [$];

    bit                pr = 1'b0;
    logic [AW-1:0]     pr_a;
    string             pr_tag;
    bit                pw = 1'b0;
    logic [AW-1:0]     pw_a;
    logic [BEAT_W-1:0] pw_d;
    logic [NB-1:0]     pw_be;

    function automatic logic [BEAT_W-1:0] merge_ref(input logic [BEAT_W-1:0] old_w,
                                                    input logic [BEAT_W-1:0] new_w,
                                                    input logic [NB-1:0] be);
        logic [BEAT_W-1:0] r;
        r = old_w;
        for (int j = 0; j < int'(NB); j++) begin
            if (be[j]) r[j*BYTE_W +: BYTE_W] = new_w[j*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [BEAT_W-1:0] act, input logic [BEAT_W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock cycle of stimulus; the model follows the requirements:
    // accept every other cycle per port (R8), beat 1 of a write in the next
    // cycle (R4), a read sees writes accepted up to its own cycle (R5, R6)
    task automatic cyc(input bit rr, input logic [AW-1:0] ra,
                       input bit wr, input logic [AW-1:0] wa,
                       input logic [BEAT_W-1:0] wd, input logic [NB-1:0] wbe,
                       input string tag);
        bit rd_acc, wr_acc;
        rd_req  = rr;
        rd_addr = ra;
        wr_req  = wr;
        wr_addr = wa;
        wr_data = wd;
        wr_be   = wbe;
        if (pw) begin
            model[pw_a][0] = merge_ref(model[pw_a][0], pw_d, pw_be);
            model[pw_a][1] = merge_ref(model[pw_a][1], wd, wbe);
        end
        if (pr) begin
            q_data.push_back(model[pr_a][0]); q_cyc.push_back(cyc_cnt + 1); q_tag.push_back(pr_tag);
            q_data.push_back(model[pr_a][1]); q_cyc.push_back(cyc_cnt + 2); q_tag.push_back(pr_tag);
        end
        rd_acc = rr && !pr;
        wr_acc = wr && !pw;
        pr     = rd_acc;
        pr_a   = ra;
        pr_tag = (rd_acc && wr_acc && ra == wa) ? "R6" : tag;
        pw     = wr_acc;
        pw_a   = wa;
        pw_d   = wd;
        pw_be  = wbe;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, '0, 1'b0, '0, '0, '0, "-");
    endtask

    // monitor: compare each read beat with the scoreboard front
    always @(negedge clk) begin
        if (running && !rst) begin
            if (rd_valid) begin
                if (q_data.size() == 0) begin
                    check(1'b0, "R8", "unexpected beat", rd_data, '0);
                end else begin
                    n_vec++;
                    if (rd_data !== q_data[0] || cyc_cnt != q_cyc[0]) begin
                        n_bad++;
                        $display("FAIL %s read beat: got %h @%0d expected %h @%0d",
                                 q_tag[0], rd_data, cyc_cnt, q_data[0], q_cyc[0]);
                    end
                    void'(q_data.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
                end
            end else begin
                check(rd_data == '0, "R3", "idle data", rd_data, '0);
                if (q_cyc.size() > 0 && q_cyc[0] <= cyc_cnt) begin
                    check(1'b0, "R2", "missing beat", rd_data, q_data[0]);
                    void'(q_data.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: run reached %0d cycles expected fewer than %0d", cyc_cnt, 20000);
        finish_run();
    end

    initial begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            model[i][0] = '0;
            model[i][1] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: quiet outputs while in reset
        check(rd_valid == 1'b0, "R1", "rd_valid in reset", BEAT_W'(rd_valid), '0);
        check(rd_data == '0, "R1", "rd_data in reset", rd_data, '0);
        rst = 1'b0;
        running = 1'b1;

        // R1: a location reads as zero after reset
        cyc(1'b1, 4'd3, 1'b0, '0, '0, '0, "R1");
        idle(3);

        // R4: full-lane write then read
        cyc(1'b0, '0, 1'b1, 4'd5, 16'h1111, 2'b11, "-");
        cyc(1'b0, '0, 1'b0, '0, 16'h2222, 2'b11, "-");
        idle(1);
        cyc(1'b1, 4'd5, 1'b0, '0, '0, '0, "R4");
        idle(3);

        // R4: partial lanes, expect 11aa / bb22
        cyc(1'b0, '0, 1'b1, 4'd5, 16'haaaa, 2'b01, "-");
        cyc(1'b0, '0, 1'b0, '0, 16'hbbbb, 2'b10, "-");
        idle(1);
        cyc(1'b1, 4'd5, 1'b0, '0, '0, '0, "R4");
        idle(3);

        // R5: read in the cycle right after the write
        cyc(1'b0, '0, 1'b1, 4'd7, 16'h7070, 2'b11, "-");
        cyc(1'b1, 4'd7, 1'b0, '0, 16'h7171, 2'b11, "R5");
        idle(4);

        // R6: same address, same cycle, partial lanes: expect ab90 / 9155
        cyc(1'b0, '0, 1'b1, 4'd9, 16'h9090, 2'b11, "-");
        cyc(1'b0, '0, 1'b0, '0, 16'h9191, 2'b11, "-");
        idle(1);
        cyc(1'b1, 4'd9, 1'b1, 4'd9, 16'hab00, 2'b10, "R6");
        cyc(1'b0, '0, 1'b0, '0, 16'hcd55, 2'b01, "-");
        idle(3);
        cyc(1'b1, 4'd9, 1'b0, '0, '0, '0, "R6");
        idle(3);

        // R9: same cycle, different addresses
        cyc(1'b1, 4'd5, 1'b1, 4'd6, 16'he6e6, 2'b11, "R9");
        cyc(1'b0, '0, 1'b0, '0, 16'hf6f6, 2'b11, "-");
        idle(1);
        cyc(1'b1, 4'd6, 1'b0, '0, '0, '0, "R9");
        idle(3);

        // R7: read before writes in the next cycle and two cycles later
        cyc(1'b1, 4'd7, 1'b1, 4'd2, 16'h0202, 2'b11, "R7");
        cyc(1'b0, '0, 1'b1, 4'd7, 16'h0303, 2'b11, "R7");
        cyc(1'b0, '0, 1'b1, 4'd2, 16'h0404, 2'b11, "-");
        cyc(1'b1, 4'd7, 1'b0, '0, 16'h0505, 2'b11, "R7");
        idle(4);
        cyc(1'b1, 4'd7, 1'b0, '0, '0, '0, "R5");
        idle(3);

        // R8: requests held high, only every other one taken
        for (int k = 0; k < 7; k++) begin
            cyc(1'b1, AW'(k + 4), 1'b1, AW'(k + 10), BEAT_W'(16'h3000 + k), 2'b11, "R8");
        end
        idle(3);
        for (int k = 10; k < 16; k++) begin
            cyc(1'b1, AW'(k), 1'b0, '0, '0, '0, "R8");
            idle(1);
        end
        idle(3);

        // mixed traffic over a few addresses to provoke collisions
        for (int k = 0; k < 400; k++) begin
            cyc(1'($urandom_range(0, 1)), AW'($urandom_range(0, 3)),
                1'($urandom_range(0, 1)), AW'($urandom_range(0, 3)),
                BEAT_W'($urandom), NB'($urandom), "R5");
        end
        idle(6);

        check(q_data.size() == 0, "R2", "beats still owed", BEAT_W'(q_data.size()), '0);
        finish_run();
    end

endmodule